// File: doc/BRIEF.md
# PMP Configuration Write Filter

This block holds a bank of physical-memory-protection configuration bytes and their address registers, and decides for every software write whether it is committed or silently dropped. A write names one entry by index and carries either a new configuration byte, a new address value, or both in the same cycle. The filter weighs the write against three things: the lock bit already stored in the target entry, the lockdown mode control, and the lock-bypass control. A write that fails the check leaves the entry exactly as it was, and no error is reported.

Two control inputs steer the filter. With lockdown off, a set lock bit makes the entry read-only, and the write-only permission pattern stays reserved. With lockdown on, that pattern becomes a legal shared-region encoding. Writes that would create an executable machine-only rule, or a locked shared code region, are refused. Raising the bypass input lifts both the lock and the executable-rule restriction. The per-entry lock bits and their OR are exported so that the security control register can freeze its bypass bit. Address matching and access checking are done elsewhere.

Top module: `pmp_cfg_write_filter`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every configuration byte and address register to zero, so all locks are released.
- R2: A configuration write to an unlocked entry whose value is legal is stored at the next clock edge, with bits 6:5 forced to zero. The byte layout is R at bit 0, W at bit 1, X at bit 2, address mode at bits 4:3 and L at bit 7. No other entry changes.
- R3: An address write is stored at the next edge unless the target entry has L=1 and bypass is 0, in which case it is dropped.
- R4: A configuration write to an entry with L=1 is dropped when bypass is 0. When bypass is 1 it is judged like a write to an unlocked entry, and this includes writes that clear L.
- R5: With lockdown at 0, a configuration write with W=1 and R=0 (bits 1:0 = 2'b10) is dropped, whatever the bypass value.
- R6: With lockdown at 1 and bypass at 0, a configuration write is dropped if its L,R,W,X value is 1001, 1010, 1011 or 1101.
- R7: With lockdown at 1, the W=1,R=0 pattern with L=0 and the L,R,W,X value 1111 are legal and are stored.
- R8: With lockdown at 1 and bypass at 1, the L,R,W,X values 1001, 1010, 1011 and 1101 are stored.
- R9: lock_vec bit i equals bit 7 of entry i, and any_lock is the OR of all lock_vec bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| addr_we | input | 1 | Address write strobe |
| wr_idx | input | IDX_W (3) | Target entry index |
| wr_cfg | input | 8 | Proposed configuration byte |
| wr_addr | input | ADDR_W (32) | Proposed address value |
| lockdown | input | 1 | Machine-mode lockdown control |
| bypass | input | 1 | Lock-bypass control |
| cfg_q | output | NUM_ENT*8 (64) | Stored configuration bytes, entry i at bits 8i+7:8i |
| addr_q | output | NUM_ENT*ADDR_W (256) | Stored address values, entry i at bits ADDR_W*i+ADDR_W-1:ADDR_W*i |
| lock_vec | output | NUM_ENT (8) | Lock bit of each entry |
| any_lock | output | 1 | OR of all lock bits |

## Verification
A wrong accept decision shows on cfg_q or addr_q at the first falling edge after the write's clock edge, because the stored state is brought straight out. A dropped legal write is caught there in the same way. A wrong lock bit shows on lock_vec and any_lock in that same cycle. It also shows one write later, when the next write to that entry is accepted or refused against the wrong lock. The bench models the whole bank and compares every entry after every operation, so a corrupted neighbour is seen in the same cycle.

// File: rtl/pmp_wf_pkg.sv
// Package: shared configuration-byte layout and the two legality rules
// of the PMP configuration write filter.
// Assumes: byte layout R=0, W=1, X=2, A=4:3, L=7; bits 6:5 unused.
package pmp_wf_pkg;

    typedef struct packed {
        logic       lock;
        logic [1:0] pad;
        logic [1:0] amode;
        logic       exec;
        logic       wr;
        logic       rd;
    } cfg_t;

    localparam logic [7:0] CFG_KEEP_MASK = 8'h9F;

    // Write-only permission pattern, reserved unless lockdown is on.
    function automatic logic rw_reserved(input logic w, input logic r);
        return w && !r;
    endfunction

    // Executable machine-only rule or locked shared code region.
    function automatic logic exec_forbidden(input logic l, input logic r,
                                            input logic w, input logic x);
        return l && ((x && !(r && w)) || (w && !r));
    endfunction

endpackage

// File: rtl/pmp_wf_decode.sv
// Module: index decoder. Turns the write index into a one-hot entry select.
// Assumes: an index at or above NUM_ENT selects nothing.
module pmp_wf_decode #(
    parameter int NUM_ENT = 8,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_ENT-1:0] sel
);

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_sel
        // one compare per entry
        assign sel[i] = (idx == IDX_W'(i));
    end

    // one-hot (or empty) select
    always_comb begin
        assert ($onehot0(sel)) else $error("p_sel_onehot_r2 violated");
    end

endmodule

// File: rtl/pmp_wf_judge.sv
// Module: write judge. A combinational decision on whether the pending
// configuration and address writes may commit.
// Assumes: cur_lock is the stored L bit of the selected entry.
module pmp_wf_judge
    import pmp_wf_pkg::*;
(
    input  logic       cur_lock,
    input  logic       new_l,
    input  logic       new_r,
    input  logic       new_w,
    input  logic       new_x,
    input  logic       lockdown,
    input  logic       bypass,
    output logic       cfg_ok,
    output logic       addr_ok
);

    logic held;
    logic reserved_hit;
    logic exec_hit;

    // evaluate the three refusal causes and combine them
    always_comb begin
        held         = cur_lock && !bypass;
        reserved_hit = !lockdown && rw_reserved(new_w, new_r);
        exec_hit     = lockdown && !bypass && exec_forbidden(new_l, new_r, new_w, new_x);
        cfg_ok       = !held && !reserved_hit && !exec_hit;
        addr_ok      = !held;
    end

endmodule

// File: rtl/pmp_wf_entry.sv
// Module: one PMP entry, holding its configuration byte and address register.
// Assumes: the load strobes are already qualified by the judge and the select.
module pmp_wf_entry
    import pmp_wf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              addr_load,
    input  cfg_t              cfg_d,
    input  logic [ADDR_W-1:0] addr_d,
    output cfg_t              cfg_q,
    output logic [ADDR_W-1:0] addr_q
);

    // configuration byte register, with the unused bits held at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_load) begin
            cfg_q     <= cfg_d;
            cfg_q.pad <= 2'b00;
        end
    end

    // address register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (addr_load) begin
            addr_q <= addr_d;
        end
    end

    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.pad == 2'b00);

endmodule

// File: rtl/pmp_cfg_write_filter.sv
// Module: PMP configuration write filter (top). A bank of NUM_ENT entries
// whose software writes pass through lock, reserved-encoding and
// executable-rule checks before they commit.
// Assumes: the lockdown and bypass controls come from the security
// register, and any_lock feeds back to freeze that register's bypass bit.
module pmp_cfg_write_filter
    import pmp_wf_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      addr_we,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [7:0]                wr_cfg,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic                      lockdown,
    input  logic                      bypass,
    output logic [NUM_ENT*8-1:0]      cfg_q,
    output logic [NUM_ENT*ADDR_W-1:0] addr_q,
    output logic [NUM_ENT-1:0]        lock_vec,
    output logic                      any_lock
);

    cfg_t              new_cfg;
    cfg_t              ent_cfg  [NUM_ENT];
    logic [ADDR_W-1:0] ent_addr [NUM_ENT];
    logic [NUM_ENT-1:0] sel;
    logic              cur_lock;
    logic              cfg_ok;
    logic              addr_ok;

    assign new_cfg = cfg_t'(wr_cfg);

    pmp_wf_decode #(.NUM_ENT(NUM_ENT)) i_decode (
        .idx (wr_idx),
        .sel (sel)
    );

    // lock bit of the selected entry
    always_comb begin
        cur_lock = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (sel[i]) cur_lock = ent_cfg[i].lock;
        end
    end

    pmp_wf_judge i_judge (
        .cur_lock (cur_lock),
        .new_l    (new_cfg.lock),
        .new_r    (new_cfg.rd),
        .new_w    (new_cfg.wr),
        .new_x    (new_cfg.exec),
        .lockdown (lockdown),
        .bypass   (bypass),
        .cfg_ok   (cfg_ok),
        .addr_ok  (addr_ok)
    );

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        pmp_wf_entry #(.ADDR_W(ADDR_W)) i_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_load  (cfg_we && sel[i] && cfg_ok),
            .addr_load (addr_we && sel[i] && addr_ok),
            .cfg_d     (new_cfg),
            .addr_d    (wr_addr),
            .cfg_q     (ent_cfg[i]),
            .addr_q    (ent_addr[i])
        );

        assign cfg_q[i*8 +: 8]           = ent_cfg[i];
        assign addr_q[i*ADDR_W +: ADDR_W] = ent_addr[i];
        assign lock_vec[i]                = ent_cfg[i].lock;

        p_locked_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && wr_idx == IDX_W'(i) && ent_cfg[i].lock && !bypass)
            |=> $stable(ent_cfg[i]));

        p_locked_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (addr_we && wr_idx == IDX_W'(i) && ent_cfg[i].lock && !bypass)
            |=> $stable(ent_addr[i]));

        p_reserved_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && wr_idx == IDX_W'(i) && !lockdown && wr_cfg[1:0] == 2'b10)
            |=> $stable(ent_cfg[i]));

        p_exec_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && wr_idx == IDX_W'(i) && lockdown && !bypass && wr_cfg[7] &&
             ({wr_cfg[0], wr_cfg[1], wr_cfg[2]} inside {3'b001, 3'b010, 3'b011, 3'b101}))
            |=> $stable(ent_cfg[i]));

        p_commit_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && wr_idx == IDX_W'(i) && cfg_ok)
            |=> (8'(ent_cfg[i]) == ($past(wr_cfg) & CFG_KEEP_MASK)));

        p_lock_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lock_vec[i]) |-> $past(cfg_we && wr_idx == IDX_W'(i)));
    end

    // summary lock flag for the security register's bypass freeze
    always_comb begin
        any_lock = |lock_vec;
    end

endmodule

// File: tb/test_pmp_cfg_write_filter.sv
module test_pmp_cfg_write_filter;

    localparam int N  = 8;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic            addr_we = 1'b0;
    logic [2:0]      wr_idx = '0;
    logic [7:0]      wr_cfg = '0;
    logic [AW-1:0]   wr_addr = '0;
    logic            lockdown = 1'b0;
    logic            bypass = 1'b0;
    logic [N*8-1:0]  cfg_q;
    logic [N*AW-1:0] addr_q;
    logic [N-1:0]    lock_vec;
    logic            any_lock;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]    m_cfg  [N];
    logic [AW-1:0] m_addr [N];
    logic [31:0]   seed = 32'h1234_5678;

    always #5 clk = ~clk;

    pmp_cfg_write_filter #(.NUM_ENT(N), .ADDR_W(AW)) i_pmp_cfg_write_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .addr_we(addr_we),
        .wr_idx(wr_idx), .wr_cfg(wr_cfg), .wr_addr(wr_addr),
        .lockdown(lockdown), .bypass(bypass), .cfg_q(cfg_q), .addr_q(addr_q),
        .lock_vec(lock_vec), .any_lock(any_lock)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    function automatic bit forbidden(input logic [7:0] v);
        logic [3:0] lrwx;
        lrwx = {v[7], v[0], v[1], v[2]};
        return lrwx inside {4'b1001, 4'b1010, 4'b1011, 4'b1101};
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [N-1:0] lk;
        for (int i = 0; i < N; i++) begin
            check(tag, $sformatf("cfg[%0d]", i), 64'(cfg_q[i*8 +: 8]), 64'(m_cfg[i]));
            check(tag, $sformatf("addr[%0d]", i), 64'(addr_q[i*AW +: AW]), 64'(m_addr[i]));
            lk[i] = m_cfg[i][7];
        end
        check("R9", "lock_vec", 64'(lock_vec), 64'(lk));
        check("R9", "any_lock", 64'(any_lock), 64'(lk != '0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            m_cfg[i]  = '0;
            m_addr[i] = '0;
        end
    endtask

    task automatic do_op(input bit cw, input bit aw, input int idx, input logic [7:0] v,
                         input logic [AW-1:0] a, input bit md, input bit bp);
        string tag;
        bit    held;
        bit    c_ok;
        held = m_cfg[idx][7] && !bp;
        c_ok = !held && !(!md && v[1:0] == 2'b10) && !(md && !bp && forbidden(v));
        if (!cw) tag = "R3";
        else if (held) tag = "R4";
        else if (!md && v[1:0] == 2'b10) tag = "R5";
        else if (md && !bp && forbidden(v)) tag = "R6";
        else if (md && bp && forbidden(v)) tag = "R8";
        else if (md && (v[1:0] == 2'b10 || {v[7], v[2:0]} == 4'b1111)) tag = "R7";
        else tag = "R2";
        @(negedge clk);
        cfg_we   = cw;
        addr_we  = aw;
        wr_idx   = 3'(idx);
        wr_cfg   = v;
        wr_addr  = a;
        lockdown = md;
        bypass   = bp;
        @(negedge clk);
        cfg_we  = 1'b0;
        addr_we = 1'b0;
        if (aw && !held) m_addr[idx] = a;
        if (cw && c_ok) m_cfg[idx] = v & 8'h9F;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_all("R1");

        // full sweep of every byte in every control combination
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 2; b++) begin
                for (int v = 0; v < 256; v++) begin
                    do_reset();
                    do_op(1'b1, 1'b1, v % N, 8'(v), AW'(v * 32'h0101_0101), m[0], b[0]);
                end
            end
        end

        // lock then attempt edits with and without bypass
        for (int e = 0; e < N; e++) begin
            do_reset();
            do_op(1'b1, 1'b0, e, 8'h99, '0, 1'b0, 1'b0);
            do_op(1'b1, 1'b0, e, 8'h03, '0, 1'b0, 1'b0);
            do_op(1'b0, 1'b1, e, 8'h00, 32'hDEAD_0000, 1'b0, 1'b0);
            do_op(1'b1, 1'b0, e, 8'h07, '0, 1'b1, 1'b0);
            do_op(1'b0, 1'b1, e, 8'h00, 32'hBEEF_0000, 1'b0, 1'b1);
            do_op(1'b1, 1'b0, e, 8'h01, '0, 1'b0, 1'b1);
            do_op(1'b1, 1'b1, e, 8'h0B, 32'h0000_1234, 1'b1, 1'b0);
        end

        // pseudo-random operation stream
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            seed = next_rand(seed);
            if (seed[31:27] == 5'd0) begin
                do_reset();
                check_all("R1");
            end else begin
                logic [31:0] s2;
                s2 = next_rand(seed);
                do_op(seed[8] | ~seed[9], seed[9], int'(seed[12:10]), s2[23:16],
                      s2, seed[13], seed[14] & seed[15]);
                seed = s2;
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule